// File: doc/BRIEF.md
# DRAM Nap and Powerdown State Controller

This block keeps the power state of one packet-protocol DRAM device. The device has two awake states, active and standby, and two sleep states, nap and powerdown. The packet decoder hands it one-cycle entry requests, a relax flag and two readiness flags: write buffer retired and all banks precharged. The controller accepts or refuses each entry. It records which awake state it left, and from then on it watches a slow serial clock, a command wire, a mode wire and a six-bit ID bus for a wake-up pattern.

All timing windows are cycle counts that arrive on input buses. Each one loads a down-counter at the transition it guards. The quiet window flags any packet that reaches this device, or any broadcast packet, too soon after entry. The dwell guards hold the device in a sleep state for a minimum time after entry. They also keep it awake for a minimum time after exit. Each refused request or wake gives a one-cycle error pulse. Leaving powerdown gives a one-cycle request to recalibrate the output current and slew-rate controls.

Top module: `lpstate_ctrl`

## Requirements
- R1: Reset puts `pwr_state` at active. The encoding is active 2'b00, standby 2'b01, nap 2'b10, powerdown 2'b11. No error or restore pulse is raised out of reset.
- R2: An entry request from active or standby is accepted when the write buffer is retired and all banks are precharged. `cmd_nap_req` moves `pwr_state` to nap and `cmd_pdn_req` moves it to powerdown, both at the next clock edge.
- R3: When `cfg_nap_selfref` is 0, nap entry is accepted whatever the readiness flags say. Powerdown entry always needs both readiness flags, and so does nap entry when `cfg_nap_selfref` is 1.
- R4: An entry request is refused when the device is already in nap or powerdown, when nap and powerdown are requested together, or when a readiness condition is missing. A refused request raises `entry_err` for one cycle and leaves the state unchanged.
- R5: Exit returns to the awake state held at entry. When entry was made from active with `cmd_relax` high, exit goes to standby.
- R6: After an accepted entry edge, `t_quiet` cycles follow in which `pkt_hit` raises `quiet_err` one cycle later. This means a request presented in the cycles ending at edges 1..`t_quiet` after entry is flagged. A later `pkt_hit` is not flagged, and `pkt_hit` never changes the state.
- R7: A wake pattern is `cmd_wire` sampled 0 on a falling `sck` edge and then 1 on the next rising edge. `sio0` sampled on that falling edge selects the state to leave: 0 for nap, 1 for powerdown. A pattern whose selection does not match the current sleep state raises `exit_err` and leaves the state unchanged. A pattern whose rising-edge `cmd_wire` is 0 is dropped with no state change and no error.
- R8: With `cfg_skip_id` = 0, `dq_id` is compared with `cfg_dev_id`. The comparison happens on the first rising `sck` edge after the start edge when `cfg_id_late` = 0, and on the second when it is 1. On a mismatch the device stays asleep and raises no error.
- R9: With `cfg_skip_id` = 1, `dq_id` is ignored and the command pattern alone wakes the device.
- R10: After nap or powerdown entry, a wake pattern that lands within `t_nap_min_stay` or `t_pdn_min_stay` cycles of the entry edge is refused with `exit_err`.
- R11: After exit from nap or powerdown, with N = `t_nap_min_gap` or `t_pdn_min_gap`, an entry request sampled at edges 1..N after the exit edge is refused. The request at edge N+1 is accepted.
- R12: `restore_req` pulses for one cycle at the edge that leaves powerdown, and never on nap exit.
- R13: A wake pattern while active or standby has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_nap_req | input | 1 | Decoded nap entry request (one cycle) |
| cmd_pdn_req | input | 1 | Decoded powerdown entry request (one cycle) |
| cmd_relax | input | 1 | Relax flag paired with an entry request |
| wbuf_retired | input | 1 | Write buffer has been retired |
| banks_precharged | input | 1 | All banks are precharged |
| cfg_nap_selfref | input | 1 | Self-refresh during nap enabled |
| cfg_skip_id | input | 1 | Wake without a device-ID match |
| cfg_id_late | input | 1 | Sample the ID on the second rising edge |
| cfg_dev_id | input | ID_W | This device's ID |
| t_quiet | input | CNT_W | Quiet window after entry, cycles |
| t_nap_min_stay | input | CNT_W | Minimum nap residence, cycles |
| t_nap_min_gap | input | CNT_W | Minimum awake time after nap exit, cycles |
| t_pdn_min_stay | input | CNT_W | Minimum powerdown residence, cycles |
| t_pdn_min_gap | input | CNT_W | Minimum awake time after powerdown exit, cycles |
| pkt_hit | input | 1 | A packet for this device, or a broadcast packet, arrived |
| sck | input | 1 | Serial wake clock (asynchronous) |
| cmd_wire | input | 1 | Serial command wire |
| sio0 | input | 1 | Wake-mode select wire |
| dq_id | input | ID_W | Device ID driven during wake |
| pwr_state | output | 2 | Current power state |
| entry_err | output | 1 | Refused entry request pulse |
| exit_err | output | 1 | Refused wake pulse |
| quiet_err | output | 1 | Packet inside the quiet window pulse |
| restore_req | output | 1 | Recalibrate current and slew-rate controls pulse |

## Verification
The bench builds the block with its defaults: 8-bit window counters, a 6-bit ID and a two-flop synchroniser. It programs the windows at run time. Small values of 2 let the random phase cycle through entries and wakes quickly. Values of 5, 40 and 60 put the edge of the quiet window, the re-entry gap and the minimum stay far enough from the serial wake pattern to place a request exactly one cycle inside and one cycle outside each bound. An `sck` half-period of four core cycles keeps the synchroniser's fixed delay small against the pattern, so both the early and the late ID sampling points can be driven with a wrong ID on the other edge.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    ST_ATTN = 2'b00,
    ST_STBY = 2'b01,
    ST_NAP  = 2'b10,
    ST_PDN  = 2'b11
  } lp_state_e;

  typedef enum logic [1:0] {
    WK_IDLE    = 2'b00,
    WK_FELL    = 2'b01,
    WK_WAIT_ID = 2'b10
  } wake_ph_e;

  function automatic logic is_low_power(input lp_state_e s);
    return (s == ST_NAP) || (s == ST_PDN);
  endfunction

  // readiness rule: both flags, unless nap is entered without self-refresh
  function automatic logic entry_precond_ok(input logic to_pdn, input logic wbuf_done,
                                            input logic banks_idle, input logic nap_selfref);
    return (wbuf_done && banks_idle) || (!to_pdn && !nap_selfref);
  endfunction

  // awake state to come back to after the sleep period
  function automatic lp_state_e resume_target(input lp_state_e from, input logic relax);
    return (from == ST_ATTN && !relax) ? ST_ATTN : ST_STBY;
  endfunction

endpackage

// File: rtl/lp_sync_edge.sv
module lp_sync_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic [DATA_W-1:0] data,
  output logic              sck_fall,
  output logic              sck_rise,
  output logic [DATA_W-1:0] data_s
);

  logic [SYNC_STAGES-1:0] sck_q;
  logic                   sck_prev;
  logic [DATA_W-1:0]      dat_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '1;
      sck_prev <= 1'b1;
      for (int i = 0; i < SYNC_STAGES; i++) dat_q[i] <= '0;
    end else begin
      sck_q    <= {sck_q[SYNC_STAGES-2:0], sck};
      sck_prev <= sck_q[SYNC_STAGES-1];
      dat_q[0] <= data;
      for (int i = 1; i < SYNC_STAGES; i++) dat_q[i] <= dat_q[i-1];
    end
  end

  assign sck_fall = sck_prev & ~sck_q[SYNC_STAGES-1];
  assign sck_rise = ~sck_prev & sck_q[SYNC_STAGES-1];
  assign data_s   = dat_q[SYNC_STAGES-1];

endmodule

// File: rtl/lp_wake_detect.sv
module lp_wake_detect
  import lp_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_fall,
  input  logic            sck_rise,
  input  logic            cmd_s,
  input  logic            sio_s,
  input  logic [ID_W-1:0] id_s,
  input  logic            skip_id,
  input  logic            id_late,
  input  logic [ID_W-1:0] dev_id,
  output logic            wake,
  output logic            wake_pdn,
  output logic            id_miss,
  output logic            broken
);

  wake_ph_e ph, ph_nxt;
  logic     mode_q;
  logic     id_match;

  assign id_match = (id_s == dev_id);

  always_comb begin
    ph_nxt  = ph;
    wake    = 1'b0;
    id_miss = 1'b0;
    broken  = 1'b0;
    unique case (ph)
      WK_IDLE: begin
        if (sck_fall && !cmd_s) ph_nxt = WK_FELL;
      end
      WK_FELL: begin
        if (sck_rise) begin
          if (!cmd_s) begin
            broken = 1'b1;
            ph_nxt = WK_IDLE;
          end else if (skip_id) begin
            wake   = 1'b1;
            ph_nxt = WK_IDLE;
          end else if (id_late) begin
            ph_nxt = WK_WAIT_ID;
          end else begin
            ph_nxt  = WK_IDLE;
            wake    = id_match;
            id_miss = !id_match;
          end
        end
      end
      WK_WAIT_ID: begin
        if (sck_rise) begin
          ph_nxt  = WK_IDLE;
          wake    = id_match;
          id_miss = !id_match;
        end
      end
      default: ph_nxt = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= WK_IDLE;
      mode_q <= 1'b0;
    end else begin
      ph <= ph_nxt;
      if (ph == WK_IDLE && sck_fall && !cmd_s) mode_q <= sio_s;
    end
  end

  assign wake_pdn = mode_q;

endmodule

// File: rtl/lp_dwell_timer.sv
module lp_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/lpstate_ctrl.sv
module lpstate_ctrl
  import lp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ID_W        = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_nap_req,
  input  logic             cmd_pdn_req,
  input  logic             cmd_relax,
  input  logic             wbuf_retired,
  input  logic             banks_precharged,
  input  logic             cfg_nap_selfref,
  input  logic             cfg_skip_id,
  input  logic             cfg_id_late,
  input  logic [ID_W-1:0]  cfg_dev_id,
  input  logic [CNT_W-1:0] t_quiet,
  input  logic [CNT_W-1:0] t_nap_min_stay,
  input  logic [CNT_W-1:0] t_nap_min_gap,
  input  logic [CNT_W-1:0] t_pdn_min_stay,
  input  logic [CNT_W-1:0] t_pdn_min_gap,
  input  logic             pkt_hit,
  input  logic             sck,
  input  logic             cmd_wire,
  input  logic             sio0,
  input  logic [ID_W-1:0]  dq_id,
  output logic [1:0]       pwr_state,
  output logic             entry_err,
  output logic             exit_err,
  output logic             quiet_err,
  output logic             restore_req
);

  localparam int BUS_W = ID_W + 2;

  lp_state_e        cur_st, ret_st;
  logic             sck_fall, sck_rise;
  logic [BUS_W-1:0] wake_bus_s;
  logic             cmd_s, sio_s;
  logic [ID_W-1:0]  id_s;
  logic             wake, wake_pdn, id_miss, broken;
  logic             guard_busy, quiet_busy;
  logic             entry_req, entry_dual, entry_go, entry_bad;
  logic             wake_kind_ok, exit_go, exit_bad;
  logic             guard_load;
  logic [CNT_W-1:0] guard_val;

  lp_sync_edge #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(BUS_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .data     ({cmd_wire, sio0, dq_id}),
    .sck_fall (sck_fall),
    .sck_rise (sck_rise),
    .data_s   (wake_bus_s)
  );

  assign cmd_s = wake_bus_s[BUS_W-1];
  assign sio_s = wake_bus_s[BUS_W-2];
  assign id_s  = wake_bus_s[ID_W-1:0];

  lp_wake_detect #(.ID_W(ID_W)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_fall (sck_fall),
    .sck_rise (sck_rise),
    .cmd_s    (cmd_s),
    .sio_s    (sio_s),
    .id_s     (id_s),
    .skip_id  (cfg_skip_id),
    .id_late  (cfg_id_late),
    .dev_id   (cfg_dev_id),
    .wake     (wake),
    .wake_pdn (wake_pdn),
    .id_miss  (id_miss),
    .broken   (broken)
  );

  // entry decision
  assign entry_req  = cmd_nap_req | cmd_pdn_req;
  assign entry_dual = cmd_nap_req & cmd_pdn_req;
  assign entry_go   = entry_req && !entry_dual && !is_low_power(cur_st) && !guard_busy &&
                      entry_precond_ok(cmd_pdn_req, wbuf_retired, banks_precharged, cfg_nap_selfref);
  assign entry_bad  = entry_req && !entry_go;

  // exit decision
  assign wake_kind_ok = (cur_st == ST_NAP && !wake_pdn) || (cur_st == ST_PDN && wake_pdn);
  assign exit_go      = wake && wake_kind_ok && !guard_busy;
  assign exit_bad     = wake && is_low_power(cur_st) && !exit_go;

  // one guard counter serves both the minimum stay and the minimum gap
  assign guard_load = entry_go | exit_go;
  always_comb begin
    if (entry_go)              guard_val = cmd_pdn_req ? t_pdn_min_stay : t_nap_min_stay;
    else if (cur_st == ST_PDN) guard_val = t_pdn_min_gap;
    else                       guard_val = t_nap_min_gap;
  end

  lp_dwell_timer #(.CNT_W(CNT_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (guard_load),
    .load_val (guard_val),
    .busy     (guard_busy)
  );

  lp_dwell_timer #(.CNT_W(CNT_W)) u_quiet (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (entry_go),
    .load_val (t_quiet),
    .busy     (quiet_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_st      <= ST_ATTN;
      ret_st      <= ST_ATTN;
      entry_err   <= 1'b0;
      exit_err    <= 1'b0;
      quiet_err   <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      entry_err   <= entry_bad;
      exit_err    <= exit_bad;
      quiet_err   <= pkt_hit && quiet_busy;
      restore_req <= exit_go && (cur_st == ST_PDN);
      if (entry_go) begin
        cur_st <= cmd_pdn_req ? ST_PDN : ST_NAP;
        ret_st <= resume_target(cur_st, cmd_relax);
      end else if (exit_go) begin
        cur_st <= ret_st;
      end
    end
  end

  assign pwr_state = cur_st;

endmodule

// File: rtl/lpstate_ctrl_chk.sv
module lpstate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_state,
  input logic       entry_err,
  input logic       exit_err,
  input logic       quiet_err,
  input logic       restore_req,
  input logic       pkt_hit,
  input logic       guard_busy,
  input logic       quiet_busy,
  input logic       wake,
  input logic       id_miss,
  input logic       entry_go
);

  assert_awake_leaves_only_to_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_state[1] |=> (pwr_state == $past(pwr_state)) || pwr_state[1]);

  assert_accepted_entry_sleeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_go |=> pwr_state[1]);

  assert_no_sleep_to_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state[1] |=> (pwr_state == $past(pwr_state)) || !pwr_state[1]);

  assert_entry_err_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    entry_err |-> pwr_state == $past(pwr_state));

  assert_exit_err_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_err |-> pwr_state == $past(pwr_state));

  assert_quiet_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_err |-> $past(pkt_hit) && $past(quiet_busy));

  assert_id_miss_no_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_miss |=> pwr_state == $past(pwr_state));

  assert_min_stay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state[1] && guard_busy) |=> pwr_state[1]);

  assert_min_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_state[1] && guard_busy) |=> !pwr_state[1]);

  assert_restore_after_pdn_R12: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> ($past(pwr_state) == 2'b11) && !pwr_state[1]);

  assert_wake_awake_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !pwr_state[1]) |=> pwr_state == $past(pwr_state));

endmodule

bind lpstate_ctrl lpstate_ctrl_chk u_lpstate_ctrl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_state   (pwr_state),
  .entry_err   (entry_err),
  .exit_err    (exit_err),
  .quiet_err   (quiet_err),
  .restore_req (restore_req),
  .pkt_hit     (pkt_hit),
  .guard_busy  (guard_busy),
  .quiet_busy  (quiet_busy),
  .wake        (wake),
  .id_miss     (id_miss),
  .entry_go    (entry_go)
);

// File: tb/lpstate_ctrl_bench.sv
`timescale 1ns/1ps
module lpstate_ctrl_bench;

  localparam int CNT_W = 8;
  localparam int ID_W  = 6;
  localparam logic [ID_W-1:0] DEV   = 6'h2D;
  localparam logic [ID_W-1:0] WRONG = 6'h12;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_nap_req, cmd_pdn_req, cmd_relax, wbuf_retired, banks_precharged;
  logic cfg_nap_selfref, cfg_skip_id, cfg_id_late;
  logic [ID_W-1:0]  cfg_dev_id, dq_id;
  logic [CNT_W-1:0] t_quiet, t_nap_min_stay, t_nap_min_gap, t_pdn_min_stay, t_pdn_min_gap;
  logic pkt_hit, sck, cmd_wire, sio0;
  logic [1:0] pwr_state;
  logic entry_err, exit_err, quiet_err, restore_req;

  int n_cmp = 0, n_bad = 0;
  int n_ee = 0, n_xe = 0, n_qe = 0, n_rr = 0;
  int cyc = 0, chg = 0;
  logic [1:0] last_st = 2'b00;
  bit done = 0;

  always #2 clk = ~clk;

  lpstate_ctrl #(.CNT_W(CNT_W), .ID_W(ID_W), .SYNC_STAGES(2)) u_lpstate_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_nap_req(cmd_nap_req), .cmd_pdn_req(cmd_pdn_req),
    .cmd_relax(cmd_relax), .wbuf_retired(wbuf_retired), .banks_precharged(banks_precharged),
    .cfg_nap_selfref(cfg_nap_selfref), .cfg_skip_id(cfg_skip_id), .cfg_id_late(cfg_id_late),
    .cfg_dev_id(cfg_dev_id), .t_quiet(t_quiet), .t_nap_min_stay(t_nap_min_stay),
    .t_nap_min_gap(t_nap_min_gap), .t_pdn_min_stay(t_pdn_min_stay), .t_pdn_min_gap(t_pdn_min_gap),
    .pkt_hit(pkt_hit), .sck(sck), .cmd_wire(cmd_wire), .sio0(sio0), .dq_id(dq_id),
    .pwr_state(pwr_state), .entry_err(entry_err), .exit_err(exit_err),
    .quiet_err(quiet_err), .restore_req(restore_req)
  );

  // pulse counters and change stamp, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (rst_n) begin
      n_ee += int'(entry_err);
      n_xe += int'(exit_err);
      n_qe += int'(quiet_err);
      n_rr += int'(restore_req);
      if (pwr_state != last_st) begin
        chg     = cyc;
        last_st = pwr_state;
      end
    end else begin
      last_st = 2'b00;
    end
  end

  function automatic bit f_pre_ok(input bit pdn, input bit wb, input bit bk, input bit sf);
    if (wb && bk) return 1'b1;
    return !pdn && !sf;
  endfunction

  function automatic logic [1:0] f_resume(input logic [1:0] from, input bit relax);
    if (from == 2'b00 && !relax) return 2'b00;
    return 2'b01;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic enter(input bit pdn, input bit relax, input bit wb, input bit bk);
    cmd_nap_req = !pdn; cmd_pdn_req = pdn; cmd_relax = relax;
    wbuf_retired = wb; banks_precharged = bk;
    tick(1);
    cmd_nap_req = 0; cmd_pdn_req = 0; cmd_relax = 0;
  endtask

  task automatic enter_both();
    cmd_nap_req = 1; cmd_pdn_req = 1; wbuf_retired = 1; banks_precharged = 1;
    tick(1);
    cmd_nap_req = 0; cmd_pdn_req = 0;
  endtask

  task automatic wake(input bit s, input logic [ID_W-1:0] id1, input logic [ID_W-1:0] id2,
                      input bit c_rise);
    cmd_wire = 0; sio0 = s; tick(4);
    sck = 0; tick(4);
    cmd_wire = c_rise; dq_id = id1; tick(4);
    sck = 1; tick(4);
    cmd_wire = 1; dq_id = id2; tick(4);
    sck = 0; tick(4);
    sck = 1; tick(4);
    cmd_wire = 0; dq_id = '0; sio0 = 0; tick(6);
  endtask

  task automatic short_timers();
    t_quiet = 2; t_nap_min_stay = 2; t_nap_min_gap = 2; t_pdn_min_stay = 2; t_pdn_min_gap = 2;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(4); rst_n = 1; tick(2);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int e0, x0, q0, r0;
    rst_n = 0; cmd_nap_req = 0; cmd_pdn_req = 0; cmd_relax = 0;
    wbuf_retired = 1; banks_precharged = 1; cfg_nap_selfref = 1;
    cfg_skip_id = 0; cfg_id_late = 0; cfg_dev_id = DEV; dq_id = '0;
    pkt_hit = 0; sck = 1; cmd_wire = 0; sio0 = 0;
    short_timers();
    void'($urandom(32'd2024));
    tick(4); rst_n = 1; tick(2);

    chk("R1 reset state", pwr_state, 0);
    chk("R1 no pulses after reset", n_ee + n_xe + n_qe + n_rr, 0);

    // R13: wake while active
    wake(0, DEV, DEV, 1);
    chk("R13 wake in active keeps state", pwr_state, 0);
    chk("R13 wake in active no error", n_xe, 0);

    // R2 / R12 nap and powerdown round trips
    enter(0, 0, 1, 1);
    chk("R2 nap entry", pwr_state, 2);
    tick(4);
    wake(0, DEV, WRONG, 1);
    chk("R5 nap exit to active", pwr_state, 0);
    chk("R12 no restore on nap exit", n_rr, 0);
    tick(4);
    enter(1, 0, 1, 1);
    chk("R2 powerdown entry", pwr_state, 3);
    tick(4);
    wake(1, DEV, WRONG, 1);
    chk("R5 powerdown exit to active", pwr_state, 0);
    chk("R12 restore on powerdown exit", n_rr, 1);
    tick(4);

    // R3 self-refresh exception
    cfg_nap_selfref = 0; e0 = n_ee;
    enter(0, 0, 0, 0);
    chk("R3 nap without readiness when selfref off", pwr_state, 2);
    tick(4); wake(0, DEV, WRONG, 1); tick(4);
    enter(1, 0, 0, 1);
    chk("R3 powerdown still needs write buffer", pwr_state, 0);
    cfg_nap_selfref = 1; tick(2);
    enter(0, 0, 1, 0);
    chk("R3 nap needs precharge when selfref on", pwr_state, 0);
    tick(1);
    chk("R3 R4 refusal pulses", n_ee - e0, 2);

    // R4 entry while asleep, dual request
    e0 = n_ee;
    enter(0, 0, 1, 1); tick(4);
    enter(1, 0, 1, 1);
    chk("R4 entry while in nap keeps nap", pwr_state, 2);
    tick(4); wake(0, DEV, WRONG, 1); tick(4);
    enter_both();
    chk("R4 dual request refused", pwr_state, 0);
    tick(1);
    chk("R4 error pulses", n_ee - e0, 2);

    // R6 quiet window, length 5
    t_quiet = 5; q0 = n_qe;
    pkt_hit = 1; tick(1); pkt_hit = 0; tick(2);
    chk("R6 no flag while awake", n_qe - q0, 0);
    enter(0, 0, 1, 1);
    tick(1);                          // j = 1
    pkt_hit = 1; tick(1); pkt_hit = 0;
    tick(2);                          // j = 4
    pkt_hit = 1; tick(2); pkt_hit = 0; // j = 4 flagged, j = 5 not
    tick(3);
    chk("R6 window edge flags", n_qe - q0, 2);
    chk("R6 packets keep state", pwr_state, 2);
    short_timers();

    // R7 wrong mode select, broken pattern
    x0 = n_xe;
    wake(1, DEV, DEV, 1);
    chk("R7 mode mismatch keeps nap", pwr_state, 2);
    chk("R7 mode mismatch error", n_xe - x0, 1);
    wake(0, DEV, DEV, 0);
    chk("R7 broken pattern keeps nap", pwr_state, 2);
    chk("R7 broken pattern no error", n_xe - x0, 1);

    // R8 ID timing
    cfg_id_late = 0;
    wake(0, WRONG, DEV, 1);
    chk("R8 early sample mismatch stays", pwr_state, 2);
    cfg_id_late = 1;
    wake(0, WRONG, DEV, 1);
    chk("R8 late sample match exits", pwr_state, 0);
    chk("R8 mismatch no error", n_xe - x0, 1);
    tick(4);
    enter(0, 0, 1, 1); tick(4);
    wake(0, DEV, WRONG, 1);
    chk("R8 late sample mismatch stays", pwr_state, 2);
    cfg_id_late = 0;

    // R9 skip ID
    cfg_skip_id = 1;
    wake(0, WRONG, WRONG, 1);
    chk("R9 skip ID exits", pwr_state, 0);
    cfg_skip_id = 0;
    tick(4);

    // R10 minimum stay
    t_nap_min_stay = 60; x0 = n_xe;
    enter(0, 0, 1, 1);
    wake(0, DEV, WRONG, 1);
    chk("R10 early wake refused", pwr_state, 2);
    chk("R10 early wake error", n_xe - x0, 1);
    tick(40);
    wake(0, DEV, WRONG, 1);
    chk("R10 wake after stay exits", pwr_state, 0);
    short_timers();
    tick(4);

    // R11 minimum gap 40
    t_nap_min_gap = 40;
    enter(0, 0, 1, 1); tick(4);
    wake(0, DEV, WRONG, 1);
    e0 = n_ee;
    while (cyc < chg + 39) tick(1);
    enter(0, 0, 1, 1);
    chk("R11 request at edge N refused", pwr_state, 0);
    enter(0, 0, 1, 1);
    chk("R11 request at edge N+1 accepted", pwr_state, 2);
    chk("R11 one refusal", n_ee - e0, 1);
    short_timers();
    tick(4); wake(0, DEV, WRONG, 1); tick(4);

    // R5 relax from active, then from standby
    enter(0, 1, 1, 1); tick(4);
    wake(0, DEV, WRONG, 1);
    chk("R5 relax sends exit to standby", pwr_state, 1);
    tick(4);
    enter(1, 0, 1, 1); tick(4);
    wake(1, DEV, WRONG, 1);
    chk("R5 standby entry returns to standby", pwr_state, 1);

    // constrained random phase
    do_reset();
    short_timers();
    begin
      logic [1:0] exp_st, exp_ret;
      int ee_exp, rr_exp;
      exp_st = 2'b00; exp_ret = 2'b00;
      e0 = n_ee; r0 = n_rr; ee_exp = 0; rr_exp = 0;
      for (int it = 0; it < 40; it++) begin
        if (exp_st[1]) begin
          bit sk, lt, bad;
          logic [ID_W-1:0] i1, i2;
          sk  = 1'($urandom % 2);
          lt  = 1'($urandom % 2);
          bad = !sk && ($urandom % 4 == 0);
          if (sk) begin
            i1 = ID_W'($urandom); i2 = ID_W'($urandom);
          end else if (lt) begin
            i1 = WRONG; i2 = bad ? WRONG : DEV;
          end else begin
            i1 = bad ? WRONG : DEV; i2 = WRONG;
          end
          cfg_skip_id = sk; cfg_id_late = lt;
          wake(exp_st == 2'b11, i1, i2, 1);
          if (!bad) begin
            if (exp_st == 2'b11) rr_exp++;
            exp_st = exp_ret;
          end
        end else begin
          bit pd, rl, wb, bk, sf;
          pd = 1'($urandom % 2); rl = 1'($urandom % 2);
          wb = 1'($urandom % 4 != 0); bk = 1'($urandom % 4 != 0); sf = 1'($urandom % 2);
          cfg_nap_selfref = sf;
          enter(pd, rl, wb, bk);
          if (f_pre_ok(pd, wb, bk, sf)) begin
            exp_ret = f_resume(exp_st, rl);
            exp_st  = pd ? 2'b11 : 2'b10;
          end else begin
            ee_exp++;
          end
        end
        tick(6);
        chk("R2 R5 random state", pwr_state, exp_st);
      end
      chk("R3 R4 random refusals", n_ee - e0, ee_exp);
      chk("R12 random restores", n_rr - r0, rr_exp);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule